// File: doc/BRIEF.md
# Ping-Pong Block Buffer for a Byte Port and a 64-Bit Array

This block sits between a host that moves data one byte at a time and a storage array that only accepts or returns whole 64-bit blocks. It holds two 64-bit registers that trade roles. In write mode the host streams bytes into one register. When that register holds eight bytes it is handed to the array for a parallel write, and the host moves on to the other register. In read mode the block fetches array blocks into whichever register is free and streams the bytes of the other one out to the host.

The host side uses valid/ready streams. Writes: a byte moves on a clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` falls whenever the input register is still waiting for its array write, so the host is throttled and no byte is ever lost. Reads: `rd_data` is valid while `rd_valid` is high and stays unchanged until `rd_ready` takes it.

The array side is a request/acknowledge port with any latency. The block addresses the array by a page number and a block-in-page number. The address is loaded at the start of an operation and advances by one block after every acknowledged transfer. Block 31 carries into block 0 of the next page. Control inputs are single-cycle pulses and only take effect while the block is idle.

Top module: `pingpong_blkbuf`

## Requirements
- R1: After reset the block is idle: `busy`, `wr_ready`, `rd_valid` and `arr_req` are all 0.
- R2: In write mode bytes are packed most significant first. The first byte of a block lands in bits 63:56 and the eighth in bits 7:0. Each full block produces one array request with `arr_we` = 1.
- R3: While one register waits on its array write, the host can fill the other register: eight more bytes are accepted with no acknowledge.
- R4: When both registers hold blocks not yet written, `wr_ready` stays 0 until the array acknowledges. The byte held back is then accepted and written in order.
- R5: The first request carries the page and block given at the start pulse. The block address rises by one after each acknowledged transfer, and block 31 rolls over to block 0 of page+1.
- R6: Once `arr_req` rises it stays high until `arr_ack`. Over that time `arr_we`, `arr_page`, `arr_block` and `arr_wdata` do not change.
- R7: A `finish` pulse in write mode pads a partly filled register and writes it. With k bytes present, the low 8−k bytes are filled with 0xFF. With no partial bytes, no extra write is made. `busy` stays 1 until the last write is acknowledged.
- R8: In read mode blocks are fetched from the start address and sent out byte by byte, bits 63:56 first. While `rd_valid` is 1 and `rd_ready` is 0, `rd_data` holds its value.
- R9: In read mode the block fetches at most two blocks ahead of the host. With no bytes taken, exactly two array reads are made.
- R10: A `finish` pulse in read mode stops new fetches and waits for any outstanding request. It then drops the buffered data and returns to idle. A later read starts clean at its own address.
- R11: `start_wr`, `start_rd` and the start address are ignored unless the block is idle. If `start_wr` and `start_rd` arrive together, write mode wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_wr | input | 1 | Pulse: begin a write operation at the start address |
| start_rd | input | 1 | Pulse: begin a read operation at the start address |
| finish | input | 1 | Pulse: end the current operation (flush or abort) |
| start_page | input | 11 | Page number sampled by a start pulse |
| start_block | input | 5 | Block-in-page sampled by a start pulse |
| busy | output | 1 | High whenever an operation is active or draining |
| wr_valid | input | 1 | Host write byte valid |
| wr_ready | output | 1 | Block can accept a write byte |
| wr_data | input | 8 | Host write byte |
| rd_valid | output | 1 | Read byte valid |
| rd_ready | input | 1 | Host takes the read byte |
| rd_data | output | 8 | Read byte |
| arr_req | output | 1 | Array transfer request, held until acknowledged |
| arr_we | output | 1 | 1 = block write, 0 = block read |
| arr_page | output | 11 | Page of the requested block |
| arr_block | output | 5 | Block within the page |
| arr_wdata | output | 64 | Block to be written |
| arr_ack | input | 1 | One-cycle acknowledge of the request |
| arr_rdata | input | 64 | Block read, valid with `arr_ack` |

## Verification
The bench stalls the array acknowledge while the host pushes bytes. A design with a single buffer would refuse the second block at once. A design that ignores back-pressure would overwrite a register still being written, and the stored blocks would come out wrong or repeated. The bench starts a write and a read at block 30 or 31 and checks the page carry: a design without it would wrap within the page. It flushes a three-byte partial block and checks the exact 0xFF padding and byte order. In read mode it stalls the host, counts array reads and checks held data. It then aborts and starts a new read, which catches over-fetching and stale bytes left from the aborted read.

// File: rtl/ppbuf_pkg.sv
package ppbuf_pkg;
  typedef enum logic [2:0] {
    MD_IDLE   = 3'd0,
    MD_WRITE  = 3'd1,
    MD_WFLUSH = 3'd2,
    MD_READ   = 3'd3,
    MD_RSTOP  = 3'd4
  } mode_e;
endpackage

// File: rtl/ppbuf_addr_ctr.sv
module ppbuf_addr_ctr #(
  parameter int PAGE_W = 11,
  parameter int BLK_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [PAGE_W-1:0] ld_page,
  input  logic [BLK_AW-1:0] ld_block,
  input  logic              step,
  output logic [PAGE_W-1:0] page,
  output logic [BLK_AW-1:0] block
);
  localparam int AW = PAGE_W + BLK_AW;

  // page and block form one counter so the block carry walks into the page
  logic [AW-1:0] cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cur <= '0;
    else if (load) cur <= {ld_page, ld_block};
    else if (step) cur <= cur + AW'(1);
  end

  assign page  = cur[AW-1:BLK_AW];
  assign block = cur[BLK_AW-1:0];
endmodule

// File: rtl/ppbuf_shreg.sv
module ppbuf_shreg #(
  parameter int BLK_W  = 64,
  parameter int BYTE_W = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              load_en,
  input  logic [BLK_W-1:0]                  load_data,
  input  logic                              shin_en,
  input  logic [BYTE_W-1:0]                 shin_byte,
  input  logic                              shout_en,
  input  logic                              pad_en,
  input  logic [$clog2(BLK_W/BYTE_W)-1:0]   pad_cnt,
  output logic [BLK_W-1:0]                  q
);
  localparam int BYTES = BLK_W / BYTE_W;

  logic [BLK_W-1:0] pad_mask;
  int unsigned      pad_sh;

  always_comb begin
    pad_sh   = BYTE_W * (BYTES - int'(pad_cnt));
    pad_mask = ~({BLK_W{1'b1}} << pad_sh);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q <= '0;
    else if (load_en)  q <= load_data;
    else if (shin_en)  q <= {q[BLK_W-BYTE_W-1:0], shin_byte};
    else if (shout_en) q <= {q[BLK_W-BYTE_W-1:0], {BYTE_W{1'b1}}};
    else if (pad_en)   q <= (q << pad_sh) | pad_mask;
  end

  // R3: host side and array side never act on the same register in one cycle
  a_r3_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_en, shin_en, shout_en, pad_en}));
endmodule

// File: rtl/ppbuf_arr_port.sv
module ppbuf_arr_port (
  input  logic clk,
  input  logic rst_n,
  input  logic issue,
  input  logic issue_we,
  input  logic arr_ack,
  output logic arr_req,
  output logic arr_we,
  output logic done
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arr_req <= 1'b0;
      arr_we  <= 1'b0;
    end else if (issue) begin
      arr_req <= 1'b1;
      arr_we  <= issue_we;
    end else if (arr_req && arr_ack) begin
      arr_req <= 1'b0;
    end
  end

  assign done = arr_req & arr_ack;

  a_r6_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    arr_req && !arr_ack |=> arr_req && $stable(arr_we));

  a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> !arr_req);
endmodule

// File: rtl/pingpong_blkbuf.sv
module pingpong_blkbuf
  import ppbuf_pkg::*;
#(
  parameter int PAGE_W = 11,
  parameter int BLK_AW = 5,
  parameter int BLK_W  = 64,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_wr,
  input  logic              start_rd,
  input  logic              finish,
  input  logic [PAGE_W-1:0] start_page,
  input  logic [BLK_AW-1:0] start_block,
  output logic              busy,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [BYTE_W-1:0] rd_data,
  output logic              arr_req,
  output logic              arr_we,
  output logic [PAGE_W-1:0] arr_page,
  output logic [BLK_AW-1:0] arr_block,
  output logic [BLK_W-1:0]  arr_wdata,
  input  logic              arr_ack,
  input  logic [BLK_W-1:0]  arr_rdata
);
  localparam int BYTES = BLK_W / BYTE_W;
  localparam int CNT_W = $clog2(BYTES);

  mode_e            mode;
  logic [1:0]       full;
  logic             host_sel, arr_sel;
  logic [CNT_W-1:0] host_cnt;
  logic [BLK_W-1:0] blk_q [2];

  logic writing, wr_fire, rd_fire, byte_step, host_last;
  logic pad_go, issue, done, start_go;

  assign writing   = (mode == MD_WRITE) || (mode == MD_WFLUSH);
  assign wr_ready  = (mode == MD_WRITE) && !full[host_sel];
  assign rd_valid  = (mode == MD_READ) && full[host_sel];
  assign wr_fire   = wr_valid && wr_ready;
  assign rd_fire   = rd_valid && rd_ready;
  assign byte_step = wr_fire || rd_fire;
  assign host_last = host_cnt == CNT_W'(BYTES - 1);
  assign pad_go    = (mode == MD_WFLUSH) && (host_cnt != '0) && !full[host_sel];
  assign start_go  = (mode == MD_IDLE) && (start_wr || start_rd);
  assign busy      = mode != MD_IDLE;

  // a write drains a full register, a read refills an empty one
  assign issue = !arr_req &&
                 ((writing && full[arr_sel]) ||
                  ((mode == MD_READ) && !full[arr_sel]));

  assign rd_data   = blk_q[host_sel][BLK_W-1 -: BYTE_W];
  assign arr_wdata = blk_q[arr_sel];

  for (genvar i = 0; i < 2; i++) begin : g_reg
    ppbuf_shreg #(.BLK_W(BLK_W), .BYTE_W(BYTE_W)) u_reg (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_en   (done && !arr_we && (arr_sel == 1'(i))),
      .load_data (arr_rdata),
      .shin_en   (wr_fire && (host_sel == 1'(i))),
      .shin_byte (wr_data),
      .shout_en  (rd_fire && (host_sel == 1'(i))),
      .pad_en    (pad_go && (host_sel == 1'(i))),
      .pad_cnt   (host_cnt),
      .q         (blk_q[i])
    );
  end

  ppbuf_arr_port u_port (
    .clk      (clk),
    .rst_n    (rst_n),
    .issue    (issue),
    .issue_we (writing),
    .arr_ack  (arr_ack),
    .arr_req  (arr_req),
    .arr_we   (arr_we),
    .done     (done)
  );

  ppbuf_addr_ctr #(.PAGE_W(PAGE_W), .BLK_AW(BLK_AW)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start_go),
    .ld_page  (start_page),
    .ld_block (start_block),
    .step     (done),
    .page     (arr_page),
    .block    (arr_block)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode     <= MD_IDLE;
      full     <= 2'b00;
      host_sel <= 1'b0;
      arr_sel  <= 1'b0;
      host_cnt <= '0;
    end else begin
      // host side: count bytes, hand over a register at the eighth
      if (byte_step) begin
        host_cnt <= host_last ? '0 : host_cnt + CNT_W'(1);
        if (host_last) begin
          full[host_sel] <= wr_fire;
          host_sel       <= ~host_sel;
        end
      end
      if (pad_go) begin
        full[host_sel] <= 1'b1;
        host_sel       <= ~host_sel;
        host_cnt       <= '0;
      end
      // array side: a write empties the register, a read fills it
      if (done) begin
        full[arr_sel] <= !arr_we;
        arr_sel       <= ~arr_sel;
      end
      unique case (mode)
        MD_IDLE: begin
          host_sel <= 1'b0;
          arr_sel  <= 1'b0;
          host_cnt <= '0;
          full     <= 2'b00;
          if (start_wr)      mode <= MD_WRITE;
          else if (start_rd) mode <= MD_READ;
        end
        MD_WRITE: if (finish) mode <= MD_WFLUSH;
        MD_READ:  if (finish) mode <= MD_RSTOP;
        MD_WFLUSH:
          if ((host_cnt == '0) && (full == 2'b00) && !arr_req) mode <= MD_IDLE;
        MD_RSTOP:
          if (!arr_req) begin
            full     <= 2'b00;
            host_cnt <= '0;
            mode     <= MD_IDLE;
          end
        default: mode <= MD_IDLE;
      endcase
    end
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_IDLE) |-> !arr_req && !wr_ready && !rd_valid);

  a_r4_hold_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (full == 2'b11) |-> !wr_ready);

  a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> {arr_page, arr_block} == $past({arr_page, arr_block}) + (PAGE_W + BLK_AW)'(1));

  a_r6_fields_held: assert property (@(posedge clk) disable iff (!rst_n)
    arr_req && !arr_ack |=> $stable({arr_page, arr_block}) && $stable(arr_wdata));

  a_r8_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready && !finish |=> rd_valid && $stable(rd_data));

  a_r9_two_ahead: assert property (@(posedge clk) disable iff (!rst_n)
    arr_req && !arr_we |-> full != 2'b11);

  a_r11_direction: assert property (@(posedge clk) disable iff (!rst_n)
    arr_req |-> arr_we == writing);
endmodule

// File: tb/pingpong_blkbuf_test.sv
module pingpong_blkbuf_test;
  localparam int HALF = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_wr = 0, start_rd = 0, finish = 0;
  logic [10:0] start_page = '0;
  logic [4:0]  start_block = '0;
  logic busy, wr_ready, rd_valid, arr_req, arr_we;
  logic wr_valid = 0, rd_ready = 0;
  logic [7:0] wr_data = '0, rd_data;
  logic [10:0] arr_page;
  logic [4:0]  arr_block;
  logic [63:0] arr_wdata, arr_rdata;
  logic arr_ack;

  int checks = 0, errors = 0;
  int lat = 1;
  bit ack_hold = 0;
  int n_wr = 0, n_rd = 0;
  logic [63:0] log_data [16];
  logic [15:0] log_addr [16];

  always #HALF clk = ~clk;

  pingpong_blkbuf uut (
    .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .start_rd(start_rd),
    .finish(finish), .start_page(start_page), .start_block(start_block),
    .busy(busy), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .arr_req(arr_req), .arr_we(arr_we), .arr_page(arr_page),
    .arr_block(arr_block), .arr_wdata(arr_wdata), .arr_ack(arr_ack),
    .arr_rdata(arr_rdata));

  function automatic logic [63:0] pat(input logic [15:0] a);
    return {a, 16'hA5C3, ~a, a ^ 16'h5A5A};
  endfunction

  function automatic logic [63:0] blk_of(input int base);
    logic [63:0] w = '0;
    for (int k = 0; k < 8; k++) w = {w[55:0], 8'(8'h10 + base + k)};
    return w;
  endfunction

  // array model: variable latency, one-cycle acknowledge
  initial begin
    arr_ack = 0; arr_rdata = '0;
    forever begin
      @(negedge clk);
      if (rst_n && arr_req) begin
        repeat (lat) @(negedge clk);
        while (ack_hold) @(negedge clk);
        if (arr_we) begin
          if (n_wr < 16) begin
            log_data[n_wr] = arr_wdata;
            log_addr[n_wr] = {arr_page, arr_block};
          end
          n_wr++;
        end else begin
          arr_rdata = pat({arr_page, arr_block});
          n_rd++;
        end
        arr_ack = 1;
        @(negedge clk);
        arr_ack = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cmd(input bit w, input bit r, input bit f,
                     input logic [10:0] pg, input logic [4:0] bl);
    start_wr = w; start_rd = r; finish = f; start_page = pg; start_block = bl;
    @(negedge clk);
    start_wr = 0; start_rd = 0; finish = 0;
  endtask

  task automatic send_byte(input logic [7:0] b, input int tmo, output bit ok);
    ok = 0; wr_valid = 1; wr_data = b;
    for (int k = 0; k < tmo && !ok; k++) begin
      #1; if (wr_ready) ok = 1;
      @(negedge clk);
    end
    wr_valid = 0;
  endtask

  task automatic get_byte(output logic [7:0] b, output bit ok);
    ok = 0; rd_ready = 1; b = '0;
    for (int k = 0; k < 100 && !ok; k++) begin
      #1; if (rd_valid) begin ok = 1; b = rd_data; end
      @(negedge clk);
    end
    rd_ready = 0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 500; k++) begin
      #1; if (!busy) break;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic t_reset();
    #1;
    chk(!busy && !wr_ready && !rd_valid && !arr_req, "R1", "idle outputs after reset",
        {busy, wr_ready, rd_valid, arr_req}, 0);
  endtask

  task automatic t_write_basic();
    bit ok;
    n_wr = 0; lat = 2;
    cmd(1, 0, 0, 11'd5, 5'd3);
    for (int i = 0; i < 8; i++) send_byte(8'(8'h11 * (i + 1)), 50, ok);
    cmd(0, 0, 1, '0, '0);
    wait_idle();
    chk(n_wr == 1, "R7", "no extra write without partial bytes", n_wr, 1);
    chk(log_data[0] == 64'h1122334455667788, "R2", "byte packing MSB first",
        log_data[0], 64'h1122334455667788);
    chk(log_addr[0] == {11'd5, 5'd3}, "R5", "first write address", log_addr[0], {11'd5, 5'd3});
  endtask

  task automatic t_pingpong();
    bit ok, all_ok;
    n_wr = 0; lat = 1; ack_hold = 1; all_ok = 1;
    cmd(1, 0, 0, 11'd2, 5'd30);
    for (int i = 0; i < 16; i++) begin
      send_byte(8'(8'h10 + i), 20, ok);
      all_ok &= ok;
    end
    chk(all_ok, "R3", "second register filled while first awaits ack", all_ok, 1);
    send_byte(8'h20, 10, ok);
    chk(!ok, "R4", "byte refused with both registers full", ok, 0);
    #1;
    chk(arr_req && arr_we && arr_page == 11'd2 && arr_block == 5'd30, "R6",
        "request held with stable address", {arr_req, arr_we, arr_page, arr_block},
        {1'b1, 1'b1, 11'd2, 5'd30});
    chk(arr_wdata == blk_of(0), "R6", "write data held", arr_wdata, blk_of(0));
    @(negedge clk);
    ack_hold = 0;
    for (int i = 16; i < 24; i++) send_byte(8'(8'h10 + i), 100, ok);
    cmd(0, 0, 1, '0, '0);
    wait_idle();
    chk(n_wr == 3, "R4", "three blocks written", n_wr, 3);
    for (int j = 0; j < 3; j++)
      chk(log_data[j] == blk_of(8 * j), "R4", "block data in order", log_data[j], blk_of(8 * j));
    chk(log_addr[1] == {11'd2, 5'd31}, "R5", "address increments", log_addr[1], {11'd2, 5'd31});
    chk(log_addr[2] == {11'd3, 5'd0}, "R5", "block 31 rolls into next page",
        log_addr[2], {11'd3, 5'd0});
  endtask

  task automatic t_flush();
    bit ok;
    n_wr = 0; lat = 5;
    cmd(1, 0, 0, 11'd0, 5'd0);
    send_byte(8'hAA, 50, ok); send_byte(8'hBB, 50, ok); send_byte(8'hCC, 50, ok);
    cmd(0, 0, 1, '0, '0);
    @(negedge clk); #1;
    chk(busy, "R7", "busy held until flush write acknowledged", busy, 1);
    wait_idle();
    chk(n_wr == 1, "R7", "partial block flushed once", n_wr, 1);
    chk(log_data[0] == 64'hAABBCCFFFFFFFFFF, "R7", "padding with ones",
        log_data[0], 64'hAABBCCFFFFFFFFFF);
  endtask

  task automatic t_read();
    bit ok, all_ok;
    logic [7:0] b, d1;
    logic [63:0] e0, e1, got0, got1;
    lat = 3; all_ok = 1;
    e0 = pat({11'd7, 5'd31}); e1 = pat({11'd8, 5'd0});
    got0 = '0; got1 = '0;
    cmd(0, 1, 0, 11'd7, 5'd31);
    for (int i = 0; i < 16; i++) begin
      get_byte(b, ok);
      all_ok &= ok;
      if (i < 8) got0 = {got0[55:0], b}; else got1 = {got1[55:0], b};
    end
    chk(all_ok, "R8", "sixteen read bytes delivered", all_ok, 1);
    chk(got0 == e0, "R8", "first block bytes MSB first", got0, e0);
    chk(got1 == e1, "R5", "read address carries into next page", got1, e1);
    for (int k = 0; k < 50; k++) begin #1; if (rd_valid) break; @(negedge clk); end
    d1 = rd_data;
    repeat (3) @(negedge clk);
    #1;
    chk(rd_valid && rd_data == d1, "R8", "read byte held while stalled", rd_data, d1);
    @(negedge clk);
    cmd(0, 0, 1, '0, '0);
    wait_idle(); #1;
    chk(!busy && !rd_valid && !arr_req, "R10", "read abort returns to idle",
        {busy, rd_valid, arr_req}, 0);
    @(negedge clk);
  endtask

  task automatic t_prefetch();
    bit ok;
    logic [7:0] b;
    logic [63:0] got;
    n_rd = 0; lat = 1; got = '0;
    cmd(0, 1, 0, 11'd1, 5'd0);
    repeat (40) @(negedge clk);
    #1;
    chk(n_rd == 2, "R9", "only two blocks fetched ahead", n_rd, 2);
    chk(!arr_req, "R9", "no third request pending", arr_req, 0);
    @(negedge clk);
    cmd(0, 0, 1, '0, '0);
    wait_idle();
    cmd(0, 1, 0, 11'd1, 5'd4);
    for (int i = 0; i < 8; i++) begin get_byte(b, ok); got = {got[55:0], b}; end
    chk(got == pat({11'd1, 5'd4}), "R10", "new read starts clean after abort",
        got, pat({11'd1, 5'd4}));
    cmd(0, 0, 1, '0, '0);
    wait_idle();
  endtask

  task automatic t_ignore();
    bit ok;
    n_wr = 0; lat = 1;
    cmd(1, 1, 0, 11'd9, 5'd0);
    #1;
    chk(wr_ready && !rd_valid, "R11", "write wins over simultaneous read",
        {wr_ready, rd_valid}, 2'b10);
    @(negedge clk);
    cmd(0, 1, 0, 11'd4, 5'd4);
    #1;
    chk(wr_ready && !rd_valid, "R11", "start while busy ignored", {wr_ready, rd_valid}, 2'b10);
    @(negedge clk);
    for (int i = 0; i < 8; i++) send_byte(8'(8'h10 + i), 50, ok);
    cmd(0, 0, 1, '0, '0);
    wait_idle();
    chk(n_wr == 1 && log_addr[0] == {11'd9, 5'd0}, "R11", "address from ignored start unused",
        log_addr[0], {11'd9, 5'd0});
    chk(log_data[0] == blk_of(0), "R11", "write data unaffected", log_data[0], blk_of(0));
  endtask

  initial begin
    #(2 * HALF * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_write_basic();
    t_pingpong();
    t_flush();
    t_read();
    t_prefetch();
    t_ignore();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule